// File: doc/BRIEF.md
# Stack and Multiple-Register Transfer Sequencer

This block turns one multiple-register transfer request into a series of single-word memory accesses. A request names the operation (push, pop, store-multiple or load-multiple), an eight-bit list of low registers, a flag that adds the link register to a push or the program counter to a pop, a base register index and the current base value. The sequencer works out the block of addresses, then issues one word access per cycle. Registers go out in ascending index order, so the lowest-numbered register lands at the lowest address. After the last access it writes the updated base back to the register file.

Push and pop always use the stack pointer (register 13) as the base. The stack is full-descending. A push therefore starts at SP minus four times the register count and leaves SP there. A pop reads upward from SP and leaves SP above the block. Store-multiple and load-multiple use increment-after addressing from a caller-chosen low register. The caller must keep that base register out of the list. A program counter loaded by a pop is not written to the register file. It is reported as a branch target with bit 0 cleared.

The controller has three states. IDLE waits for `start`. IDLE to XFER is taken on `start` when the effective list is not empty. IDLE to WBACK is taken on `start` when the effective list is empty. XFER issues one access per cycle. It stays in XFER while registers remain, and goes from XFER to WBACK after the last one. WBACK writes the base and pulses `done`, then always goes from WBACK to IDLE.

Top module: `mxs_seq`

## Requirements
- R1: A push (op code 0) uses register 13 as base. It stores to addresses from base_val − 4·n upward, where n is the number of registers in the effective list, and writes base_val − 4·n back to register 13.
- R2: A pop (op code 1) uses register 13 as base. It loads from addresses from base_val upward and writes base_val + 4·n back to register 13.
- R3: Registers are transferred in ascending index order, one 32-bit word per cycle on consecutive cycles. Addresses rise by 4 per access, so the lowest-numbered register sits at the lowest address.
- R4: A store-multiple (op code 2) uses the low register given by base_sel as base. It stores from base_val upward, driving acc_wdata with rf_rdata for the register in acc_reg, and writes base_val + 4·n back to that register.
- R5: A load-multiple (op code 3) uses the low register given by base_sel as base. It loads from base_val upward, writes each word from mem_rdata into register acc_reg in the same cycle (rf_we, rf_widx, rf_wdata), and writes base_val + 4·n back to the base.
- R6: With extra_en set, a push also stores register 14 after the low registers, at the highest address. A pop also loads register 15 last. That word is not written to the register file. Instead br_valid is raised, and br_target equals the loaded word with bit 0 cleared.
- R7: extra_en has no effect on store-multiple and load-multiple.
- R8: done pulses for one cycle, in the cycle the base is written back. That cycle comes right after the last access. With an empty effective list it is the first cycle after start, and the base is written back unchanged.
- R9: A start pulse while busy is high is ignored. The running transfer is not disturbed and no further access follows its done.
- R10: During and after reset the block is idle: busy, acc_valid, rf_we, br_valid and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled in IDLE only |
| op | input | 2 | 0 push, 1 pop, 2 store-multiple, 3 load-multiple |
| reg_list | input | 8 | Bit i selects register i |
| extra_en | input | 1 | Adds LR to a push or PC to a pop |
| base_sel | input | 3 | Base register for store/load-multiple |
| base_val | input | 32 | Current value of the base register |
| rf_rdata | input | 32 | Register file read data for acc_reg |
| mem_rdata | input | 32 | Memory read data for acc_addr, same cycle |
| busy | output | 1 | High from XFER until the end of WBACK |
| acc_valid | output | 1 | A memory access is issued this cycle |
| acc_write | output | 1 | 1 store, 0 load |
| acc_addr | output | 32 | Word address of the access |
| acc_reg | output | 4 | Register index of the access |
| acc_wdata | output | 32 | Store data |
| rf_we | output | 1 | Register file write strobe |
| rf_widx | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| br_valid | output | 1 | Pop loaded the program counter |
| br_target | output | 32 | Branch target with bit 0 cleared |
| done | output | 1 | Base writeback cycle |

## Verification
The case that is hardest to reach is a start pulse that arrives while a transfer is running. The bench raises start, with a different operation and a full list, in the first XFER cycle of a push. It then checks two things: every access still matches the original push, and the ports stay quiet for several cycles after done. Pops that include the program counter also need care, because the loaded word must show up as a branch target rather than as a register write. For this reason the memory model returns words with bit 0 set.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
    localparam int REG_W = 4;
    localparam logic [REG_W-1:0] IDX_SP = 4'd13;
    localparam logic [REG_W-1:0] IDX_LR = 4'd14;
    localparam logic [REG_W-1:0] IDX_PC = 4'd15;

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_POP  = 2'd1,
        OP_STM  = 2'd2,
        OP_LDM  = 2'd3
    } mxs_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_XFER  = 2'd1,
        S_WBACK = 2'd2
    } mxs_state_e;
endpackage

// File: rtl/mxs_plan.sv
module mxs_plan
    import mxs_pkg::*;
#(
    parameter int N_LOW      = 8,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int NB  = N_LOW + 1,
    localparam int CW  = $clog2(NB + 1),
    localparam int BSW = $clog2(N_LOW)
) (
    input  logic [1:0]       op,
    input  logic [N_LOW-1:0] reg_list,
    input  logic             extra_en,
    input  logic [BSW-1:0]   base_sel,
    input  logic [AW-1:0]    base_val,
    output logic [NB-1:0]    mask,
    output logic [AW-1:0]    first_addr,
    output logic [AW-1:0]    new_base,
    output logic [REG_W-1:0] base_idx,
    output logic             is_load
);
    logic          is_stack;
    logic [CW-1:0] count;
    logic [AW-1:0] span;

    assign is_stack = (op == OP_PUSH) || (op == OP_POP);
    assign mask     = {extra_en & is_stack, reg_list};

    always_comb begin
        count = '0;
        for (int i = 0; i < NB; i++) begin
            count = count + CW'(mask[i]);
        end
    end

    assign span = AW'(count) * AW'(WORD_BYTES);

    always_comb begin
        unique case (mxs_op_e'(op))
            OP_PUSH: begin
                first_addr = base_val - span;
                new_base   = base_val - span;
                base_idx   = IDX_SP;
                is_load    = 1'b0;
            end
            OP_POP: begin
                first_addr = base_val;
                new_base   = base_val + span;
                base_idx   = IDX_SP;
                is_load    = 1'b1;
            end
            OP_STM: begin
                first_addr = base_val;
                new_base   = base_val + span;
                base_idx   = REG_W'(base_sel);
                is_load    = 1'b0;
            end
            default: begin
                first_addr = base_val;
                new_base   = base_val + span;
                base_idx   = REG_W'(base_sel);
                is_load    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/mxs_pick.sv
module mxs_pick #(
    parameter int NB = 9,
    localparam int PW = $clog2(NB)
) (
    input  logic [NB-1:0] vec,
    output logic [PW-1:0] pos,
    output logic [NB-1:0] rest,
    output logic          last
);
    always_comb begin
        pos = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (vec[i]) pos = PW'(i);
        end
    end

    assign rest = vec & (vec - NB'(1));
    assign last = (rest == '0);
endmodule

// File: rtl/mxs_seq.sv
module mxs_seq
    import mxs_pkg::*;
#(
    parameter int N_LOW      = 8,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int NB  = N_LOW + 1,
    localparam int PW  = $clog2(NB),
    localparam int BSW = $clog2(N_LOW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [N_LOW-1:0] reg_list,
    input  logic             extra_en,
    input  logic [BSW-1:0]   base_sel,
    input  logic [AW-1:0]    base_val,
    input  logic [DW-1:0]    rf_rdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             busy,
    output logic             acc_valid,
    output logic             acc_write,
    output logic [AW-1:0]    acc_addr,
    output logic [REG_W-1:0] acc_reg,
    output logic [DW-1:0]    acc_wdata,
    output logic             rf_we,
    output logic [REG_W-1:0] rf_widx,
    output logic [DW-1:0]    rf_wdata,
    output logic             br_valid,
    output logic [AW-1:0]    br_target,
    output logic             done
);
    mxs_state_e       state;
    logic [NB-1:0]    pend;
    logic [AW-1:0]    addr;
    logic [AW-1:0]    wb_val;
    logic [REG_W-1:0] wb_idx;
    logic             is_load;

    logic [NB-1:0]    p_mask;
    logic [AW-1:0]    p_first;
    logic [AW-1:0]    p_new;
    logic [REG_W-1:0] p_idx;
    logic             p_load;
    logic [PW-1:0]    k_pos;
    logic [NB-1:0]    k_rest;
    logic             k_last;
    logic [REG_W-1:0] xfer_reg;

    mxs_plan #(.N_LOW(N_LOW), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_plan (
        .op(op), .reg_list(reg_list), .extra_en(extra_en),
        .base_sel(base_sel), .base_val(base_val),
        .mask(p_mask), .first_addr(p_first), .new_base(p_new),
        .base_idx(p_idx), .is_load(p_load)
    );

    mxs_pick #(.NB(NB)) u_pick (
        .vec(pend), .pos(k_pos), .rest(k_rest), .last(k_last)
    );

    // State register and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            pend    <= '0;
            addr    <= '0;
            wb_val  <= '0;
            wb_idx  <= '0;
            is_load <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        pend    <= p_mask;
                        addr    <= p_first;
                        wb_val  <= p_new;
                        wb_idx  <= p_idx;
                        is_load <= p_load;
                        state   <= (p_mask == '0) ? S_WBACK : S_XFER;
                    end
                end
                S_XFER: begin
                    pend <= k_rest;
                    addr <= addr + AW'(WORD_BYTES);
                    if (k_last) state <= S_WBACK;
                end
                S_WBACK: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign xfer_reg = (k_pos == PW'(N_LOW)) ? (is_load ? IDX_PC : IDX_LR)
                                            : REG_W'(k_pos);

    // Outputs
    always_comb begin
        busy      = (state != S_IDLE);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        acc_addr  = '0;
        acc_reg   = '0;
        acc_wdata = '0;
        rf_we     = 1'b0;
        rf_widx   = '0;
        rf_wdata  = '0;
        br_valid  = 1'b0;
        br_target = '0;
        done      = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_XFER: begin
                acc_valid = 1'b1;
                acc_write = !is_load;
                acc_addr  = addr;
                acc_reg   = xfer_reg;
                if (!is_load) begin
                    acc_wdata = rf_rdata;
                end else if (xfer_reg == IDX_PC) begin
                    br_valid  = 1'b1;
                    br_target = AW'(mem_rdata) & ~AW'(1);
                end else begin
                    rf_we    = 1'b1;
                    rf_widx  = xfer_reg;
                    rf_wdata = mem_rdata;
                end
            end
            S_WBACK: begin
                rf_we    = 1'b1;
                rf_widx  = wb_idx;
                rf_wdata = DW'(wb_val);
                done     = 1'b1;
            end
            default: ;
        endcase
    end

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && $past(acc_valid) |-> acc_addr == $past(acc_addr) + AW'(WORD_BYTES));
    a_r3_reg_rising: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && $past(acc_valid) |-> acc_reg > $past(acc_reg));
    a_r8_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !acc_valid && rf_we);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    a_r6_pc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> !rf_we && !acc_write && acc_reg == IDX_PC && !br_target[0]);
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !done |=> busy);
endmodule

// File: tb/mxs_seq_bench.sv
module mxs_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [7:0]  reg_list = 8'd0;
    logic        extra_en = 1'b0;
    logic [2:0]  base_sel = 3'd0;
    logic [31:0] base_val = 32'd0;
    logic [31:0] rf_rdata, mem_rdata;
    logic        busy, acc_valid, acc_write, rf_we, br_valid, done;
    logic [31:0] acc_addr, acc_wdata, rf_wdata, br_target;
    logic [3:0]  acc_reg, rf_widx;

    logic [31:0] mem [0:63];
    logic [31:0] rf  [0:15];
    int nchk = 0;
    int nerr = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    assign mem_rdata = mem[acc_addr[7:2]];
    assign rf_rdata  = rf[acc_reg];

    mxs_seq u_mxs_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reg_list(reg_list),
        .extra_en(extra_en), .base_sel(base_sel), .base_val(base_val),
        .rf_rdata(rf_rdata), .mem_rdata(mem_rdata), .busy(busy),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_reg(acc_reg), .acc_wdata(acc_wdata), .rf_we(rf_we),
        .rf_widx(rf_widx), .rf_wdata(rf_wdata), .br_valid(br_valid),
        .br_target(br_target), .done(done)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [7:0] lst, input logic ex,
                          input logic [2:0] bs, input logic [31:0] bv,
                          input logic poke, input string rq);
        logic [3:0]  er [0:8];
        int          n = 0;
        logic        ld, stk;
        logic [31:0] a0, nb, a, w;
        logic [3:0]  bi;
        stk = (o < 2);
        ld  = (o == 2'd1) || (o == 2'd3);
        for (int i = 0; i < 8; i++) if (lst[i]) begin er[n] = 4'(i); n++; end
        if (stk && ex) begin er[n] = ld ? 4'd15 : 4'd14; n++; end
        bi = stk ? 4'd13 : {1'b0, bs};
        a0 = (o == 2'd0) ? bv - 32'(4 * n) : bv;
        nb = (o == 2'd0) ? bv - 32'(4 * n) : bv + 32'(4 * n);
        @(negedge clk);
        op = o; reg_list = lst; extra_en = ex; base_sel = bs; base_val = bv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= n; k++) begin
            if (k < n) begin
                a = a0 + 32'(4 * k);
                chk(rq, "acc_valid", 32'(acc_valid), 32'd1);
                chk(rq, "acc_addr", acc_addr, a);
                chk(rq, "acc_reg", 32'(acc_reg), 32'(er[k]));
                chk(rq, "acc_write", 32'(acc_write), 32'(!ld));
                chk("R8", "done early", 32'(done), 32'd0);
                w = mem[a[7:2]];
                if (!ld) chk(rq, "acc_wdata", acc_wdata, rf[er[k]]);
                else if (er[k] == 4'd15) begin
                    chk("R6", "br_valid", 32'(br_valid), 32'd1);
                    chk("R6", "br_target", br_target, w & ~32'd1);
                    chk("R6", "rf_we on pc", 32'(rf_we), 32'd0);
                end else begin
                    chk(rq, "rf_we", 32'(rf_we), 32'd1);
                    chk(rq, "rf_widx", 32'(rf_widx), 32'(er[k]));
                    chk(rq, "rf_wdata", rf_wdata, w);
                end
                if (poke && k == 0) begin
                    op = 2'd3; reg_list = 8'hFF; base_val = 32'h0; start = 1'b1;
                end
            end else begin
                chk("R8", "done", 32'(done), 32'd1);
                chk("R8", "acc_valid at wb", 32'(acc_valid), 32'd0);
                chk(rq, "wb idx", 32'(rf_widx), 32'(bi));
                chk(rq, "wb val", rf_wdata, nb);
                chk(rq, "wb we", 32'(rf_we), 32'd1);
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk("R8", "idle after done", 32'(busy), 32'd0);
        if (poke) begin
            for (int j = 0; j < 3; j++) begin
                chk("R9", "no access after done", 32'(acc_valid | done), 32'd0);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset();
        chk("R10", "busy", 32'(busy), 32'd0);
        chk("R10", "acc_valid", 32'(acc_valid), 32'd0);
        chk("R10", "rf_we", 32'(rf_we), 32'd0);
        chk("R10", "br_valid", 32'(br_valid), 32'd0);
        chk("R10", "done", 32'(done), 32'd0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0001 + 32'(i << 8);
        for (int i = 0; i < 16; i++) rf[i] = 32'hA500_0000 + 32'(i * 3);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_op(2'd0, 8'b1010_0101, 1'b1, 3'd0, 32'h80, 1'b0, "R1_R3_R6");
        run_op(2'd1, 8'b0001_1010, 1'b1, 3'd0, 32'h40, 1'b0, "R2_R6");
        run_op(2'd1, 8'hFF, 1'b1, 3'd0, 32'h10, 1'b0, "R2_R3");
        run_op(2'd2, 8'b1100_0001, 1'b1, 3'd3, 32'h20, 1'b0, "R4_R7");
        run_op(2'd3, 8'h0F, 1'b0, 3'd5, 32'h90, 1'b0, "R5");
        run_op(2'd3, 8'b0100_0010, 1'b1, 3'd0, 32'hA0, 1'b0, "R5_R7");
        run_op(2'd0, 8'h00, 1'b0, 3'd0, 32'h60, 1'b0, "R8");
        run_op(2'd2, 8'h00, 1'b1, 3'd2, 32'h30, 1'b0, "R8_R7");
        run_op(2'd0, 8'b0011_0000, 1'b1, 3'd0, 32'hC0, 1'b1, "R9_R1");
        finish_run();
    end
endmodule